// File: doc/BRIEF.md
# Write-Once Trace Port Configuration with Message-Clock Divider

This block holds the single configuration word of a trace/debug output port and derives the port's message clock from the system clock. Three settings are kept:
- a port-width mode that tells downstream pin logic whether to drive the reduced or the full set of data-out pins;
- a message-clock enable;
- a 3-bit divide code.

The register accepts exactly one write after reset. That first write loads every field at once, and the register then stays frozen until the next reset. Software can read the stored settings back at any time.

The divider turns the stored divide code into a ratio of 1, 2, 4 or 8. It produces two outputs: a one-cycle enable strobe every N system cycles, and, for ratios of 2 or more, a 50%-duty divided clock. Every reserved divide code runs as divide-by-2. While the enable bit is clear, the divider counter is held at zero and both outputs stay low. Enabling the clock therefore always starts from a clean phase.

Top module: `tport_cfg`

## Requirements
- R1: After reset the readback is 0x00000000, the mode output is 0 (reduced), and both the strobe and the divided clock are low.
- R2: The first write after reset stores bit 31 (mode), bit 29 (clock enable) and bits 28:26 (divide code). From the following cycle the readback shows them in those same positions.
- R3: Bit 30 and bits 25:0 of the readback are always zero, whatever value was written.
- R4: Once a write has been accepted, every further write leaves the readback, the mode output and the divider behaviour unchanged.
- R5: The mode output equals the stored bit 31: 0 selects the reduced pin set, 1 selects the full pin set.
- R6: While the stored enable bit is 0, the strobe and the divided clock stay low.
- R7: With the enable bit set, divide code 000 gives ratio 1, 001 gives 2, 011 gives 4 and 111 gives 8. The strobe is high in the last cycle of each N-cycle period, counting from the first cycle after the accepted write (cycle N-1, 2N-1, ...). For ratio 1 it is high every cycle.
- R8: The reserved divide codes 010, 100, 101 and 110 behave exactly like 001 (ratio 2).
- R9: For ratios of 2 or more, the divided clock is low for the first N/2 cycles of each period and high for the last N/2 cycles. For ratio 1 it stays low.
- R10: Reset clears the write lock, so the first write after each reset is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write request |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Readback of stored fields, reserved bits zero |
| full_mode | output | 1 | 1 = full data-out pin set, 0 = reduced |
| mclk_tick | output | 1 | Message-clock enable strobe, one cycle per period |
| mclk_out | output | 1 | 50%-duty divided message clock |

## Verification
Two kinds of internal fault show up quickly at the ports:
- A lock flag that fails to set, or that clears early, lets a second write reach the readback in the very next cycle.
- A wrong decode, or a counter that wraps at the wrong value, moves the first strobe away from cycle N-1 after the write. Within one period of at most eight cycles, the strobe and the divided clock then disagree with the expected pattern.

A counter that keeps running while the clock is disabled shows up when a divided clock or strobe appears during the quiet window. Every divide code, reserved ones included, is therefore checked cycle by cycle over four full periods, each after its own reset.

// File: rtl/tport_cfg_pkg.sv
package tport_cfg_pkg;

    localparam int REG_W    = 32;
    localparam int MODE_BIT = 31;
    localparam int EN_BIT   = 29;
    localparam int DIV_LSB  = 26;
    localparam int DIV_W    = 3;
    localparam int CNT_W    = 3;

    typedef enum logic {
        PORT_REDUCED = 1'b0,
        PORT_FULL    = 1'b1
    } port_mode_e;

    typedef struct packed {
        port_mode_e       mode;
        logic             clk_en;
        logic [DIV_W-1:0] div_code;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] last;    // terminal count (N-1)
        logic [CNT_W-1:0] half;    // first count with the clock high (N/2)
        logic             bypass;  // ratio 1: strobe every cycle, clock low
    } div_sel_t;

    function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] d);
        cfg_t c;
        c.mode     = port_mode_e'(d[MODE_BIT]);
        c.clk_en   = d[EN_BIT];
        c.div_code = d[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input cfg_t c);
        logic [REG_W-1:0] r;
        r                    = '0;
        r[MODE_BIT]          = c.mode;
        r[EN_BIT]            = c.clk_en;
        r[DIV_LSB +: DIV_W]  = c.div_code;
        return r;
    endfunction

    function automatic div_sel_t decode_div(input logic [DIV_W-1:0] code);
        div_sel_t s;
        case (code)
            3'b000: begin
                s.last = CNT_W'(0); s.half = CNT_W'(0); s.bypass = 1'b1;
            end
            3'b011: begin
                s.last = CNT_W'(3); s.half = CNT_W'(2); s.bypass = 1'b0;
            end
            3'b111: begin
                s.last = CNT_W'(7); s.half = CNT_W'(4); s.bypass = 1'b0;
            end
            default: begin // 001 and every reserved code run at ratio 2
                s.last = CNT_W'(1); s.half = CNT_W'(1); s.bypass = 1'b0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tport_cfg_reg.sv
module tport_cfg_reg
    import tport_cfg_pkg::*;
#(
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o,
    output logic              locked_o,
    output logic [DATA_W-1:0] rd_data_o
);

    cfg_t cfg_q;
    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            locked_q <= 1'b0;
        end else if (wr_en && !locked_q) begin
            cfg_q    <= unpack_cfg(REG_W'(wr_data));
            locked_q <= 1'b1;
        end
    end

    assign cfg_o     = cfg_q;
    assign locked_o  = locked_q;
    assign rd_data_o = DATA_W'(pack_cfg(cfg_q));

    AST_FIRST_WRITE_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !locked_q) |=> locked_q); // R2
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q); // R4
    AST_LATE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (locked_q && wr_en) |=> $stable(cfg_q)); // R4

endmodule

// File: rtl/tport_div_decode.sv
module tport_div_decode
    import tport_cfg_pkg::*;
#(
    parameter int CODE_W = DIV_W
) (
    input  logic [CODE_W-1:0] code_i,
    output div_sel_t          sel_o
);

    assign sel_o = decode_div(DIV_W'(code_i));

endmodule

// File: rtl/tport_clkgen.sv
module tport_clkgen
    import tport_cfg_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_i,
    input  div_sel_t sel_i,
    output logic     tick_o,
    output logic     mclk_o
);

    logic [CW-1:0] cnt_q, cnt_next;
    logic          mclk_q;
    logic [CW-1:0] last_w, half_w;

    assign last_w = CW'(sel_i.last);
    assign half_w = CW'(sel_i.half);

    always_comb begin
        if (!en_i)
            cnt_next = '0;
        else if (cnt_q >= last_w)
            cnt_next = '0;
        else
            cnt_next = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_next;
            mclk_q <= en_i && !sel_i.bypass && (cnt_next >= half_w);
        end
    end

    assign tick_o = en_i && (cnt_q == last_w);
    assign mclk_o = mclk_q;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !mclk_o); // R6
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (cnt_q <= last_w)); // R7
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !sel_i.bypass) |=> !tick_o); // R7
    AST_BYPASS_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        sel_i.bypass |=> !mclk_o); // R9

endmodule

// File: rtl/tport_cfg.sv
module tport_cfg
    import tport_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        full_mode,
    output logic        mclk_tick,
    output logic        mclk_out
);

    cfg_t     cfg;
    logic     locked;
    div_sel_t div_sel;

    tport_cfg_reg #(.DATA_W(REG_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cfg_o    (cfg),
        .locked_o (locked),
        .rd_data_o(rd_data)
    );

    tport_div_decode #(.CODE_W(DIV_W)) u_dec (
        .code_i(cfg.div_code),
        .sel_o (div_sel)
    );

    tport_clkgen #(.CW(CNT_W)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .en_i  (cfg.clk_en),
        .sel_i (div_sel),
        .tick_o(mclk_tick),
        .mclk_o(mclk_out)
    );

    assign full_mode = (cfg.mode == PORT_FULL);

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(full_mode)); // R5

endmodule

// File: tb/tb_tport_cfg.sv
`timescale 1ns/1ps
module tb_tport_cfg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        full_mode, mclk_tick, mclk_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tport_cfg dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .full_mode(full_mode),
        .mclk_tick(mclk_tick), .mclk_out(mclk_out)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // drive on a falling edge, commit at the next rising edge, return at the following falling edge
    task automatic write_cfg(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic [31:0] expect_rd(input logic [31:0] d);
        return d & 32'hBC00_0000;
    endfunction

    function automatic int ratio_of(input int code);
        case (code)
            0: return 1;
            3: return 4;
            7: return 8;
            default: return 2;
        endcase
    endfunction

    // observe 4*n cycles starting at the first falling edge after the write
    task automatic check_pattern(input int n, input string req_t, input string req_c);
        int tick_bad = 0;
        int clk_bad = 0;
        for (int k = 0; k < 4 * n; k++) begin
            bit et = ((k % n) == n - 1);
            bit ec = (n >= 2) && ((k % n) >= n / 2);
            if (mclk_tick !== et) tick_bad++;
            if (mclk_out !== ec) clk_bad++;
            @(negedge clk);
        end
        chk(tick_bad == 0, req_t, tick_bad, 0);
        chk(clk_bad == 0, req_c, clk_bad, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(rd_data === 32'h0, "R1 readback", rd_data, 32'h0);
        chk(full_mode === 1'b0, "R1 mode", full_mode, 0);
        chk(mclk_tick === 1'b0 && mclk_out === 1'b0, "R1 clock outputs",
            {mclk_tick, mclk_out}, 0);
    endtask

    task automatic t_readback_and_lock();
        do_reset();
        write_cfg(32'hFFFF_FFFF);
        chk(rd_data === expect_rd(32'hFFFF_FFFF), "R2 readback", rd_data, 32'hBC00_0000);
        chk((rd_data & 32'h43FF_FFFF) === 32'h0, "R3 reserved zero",
            rd_data & 32'h43FF_FFFF, 0);
        chk(full_mode === 1'b1, "R5 full mode", full_mode, 1);
        write_cfg(32'h0000_0000);
        chk(rd_data === 32'hBC00_0000, "R4 second write readback", rd_data, 32'hBC00_0000);
        chk(full_mode === 1'b1, "R4 second write mode", full_mode, 1);
        // counter was already running; the divide-by-8 period must persist
        begin
            int ticks = 0;
            int highs = 0;
            for (int k = 0; k < 32; k++) begin
                if (mclk_tick) ticks++;
                if (mclk_out) highs++;
                @(negedge clk);
            end
            chk(ticks == 4, "R4 divider unchanged ticks", ticks, 4);
            chk(highs == 16, "R4 divider unchanged duty", highs, 16);
        end
    endtask

    task automatic t_disabled();
        bit seen;
        do_reset();
        write_cfg(32'h1C00_0000); // enable clear, code 111, reduced mode
        chk(rd_data === 32'h1C00_0000, "R2 readback code only", rd_data, 32'h1C00_0000);
        chk(full_mode === 1'b0, "R5 reduced mode", full_mode, 0);
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (mclk_tick || mclk_out) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R6 quiet while disabled", seen, 0);
        write_cfg(32'hA000_0000); // late attempt to enable
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (mclk_tick || mclk_out) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && rd_data === 32'h1C00_0000, "R4 late enable ignored",
            rd_data, 32'h1C00_0000);
    endtask

    task automatic t_all_codes();
        for (int c = 0; c < 8; c++) begin
            logic [31:0] d = 32'h2000_0000 | (32'(c) << 26) | 32'h4000_1234;
            int n = ratio_of(c);
            bit rsv = (c == 2) || (c == 4) || (c == 5) || (c == 6);
            do_reset();
            write_cfg(d);
            if (c == 7)
                chk(rd_data === expect_rd(d), "R10 write accepted after reset",
                    rd_data, expect_rd(d));
            check_pattern(n, rsv ? "R8 reserved code strobe" : "R7 strobe period",
                          "R9 divided clock duty");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_readback_and_lock();
        t_disabled();
        t_all_codes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule